// File: doc/BRIEF.md
# Coarse-Grained Custom-Instruction Array

This block is an execution unit that sits beside a processor pipeline and runs one custom instruction at a time. The instruction is carried out by an eight-row grid of combinational functional units. Each unit computes an integer logical, add/subtract, shift or compare result. Its two operands come from a small set of places: the row above, its own row's external inputs, the immediate, a long link from a shallower row, or, in two rows, the unit to its left. How every unit is set up is held in a context store. Each context has one word per unit and one header word. The header gives the dataflow depth, the instruction count, and where the branch condition and the store address and data are taken from.

Software first loads a context through the write port. The pipeline then raises `ex_start` with a context number, the register operands, an immediate and the current program counter. A few cycles later the block pulses `ex_done`. At that point it returns the outputs of the deepest active row, an optional store request, a branch-taken flag and the next program counter. The latency grows with the configured depth, one cycle for every two rows.

Top module: `rfu_array`

## Requirements
- R1: While reset is held and after its release, `ex_done`, `ex_busy`, `st_valid`, `br_taken`, `ex_result` and `next_pc` are all zero.
- R2: A unit word holds the opcode in bits [3:0], operand A select in [8:4], operand B select in [13:9] and the shift amount in [18:14]. The opcodes are: 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 NOR, 7 A shifted left, 8 A shifted right logically, 9 A shifted right arithmetically, 10 signed A<B, 11 unsigned A<B, 12 A==B and 13 A!=B. Compares give 0 or 1.
- R3: Operand select codes 0-7 take the unit of that column in the row above, and read zero in row 0. Codes 8+k take the row's k-th external input. Code 16 takes the immediate and code 20 gives zero. Global operand slots are spread over rows 0 to 4 as follows: row 0 gets slots 0-6, row 1 slots 7-8, row 2 slots 9-10, row 3 slots 11-12 and row 4 slot 13.
- R4: Code 17 selects the first long link of a row and code 18 its second. Each link carries the last-column unit of an earlier row. Row 2 sees row 0. Row 3 sees row 0 on code 17 and row 1 on code 18. Row 4 sees row 0.
- R5: Code 19 gives the output of the unit to the left in rows 2 and 3, and gives zero in every other row.
- R6: An all-zero unit word makes that unit pass through column 0 of the row above.
- R7: The header sits in slot 32, after the unit slots, which are numbered row*4+column. Its fields are: depth in [3:0], branch enable in [4], store enable in [5], instruction count in [9:6], branch column in [11:10], store-address column in [13:12] and store-data column in [15:14]. `ex_done` is a one-cycle pulse that appears ceil(depth/2) clock edges after the edge that accepts `ex_start`. `ex_busy` is high from acceptance until that edge.
- R8: `ex_start` raised while the block is busy is ignored. It gives no extra `ex_done` and does not change the results.
- R9: `ex_result` carries the four units of row depth-1, with column c at bits [32c+31:32c]. It holds its value until the next `ex_done`.
- R10: With store enable set, `st_valid` pulses together with `ex_done`. `st_addr` and `st_data` then carry the selected columns of the final row.
- R11: The branch is taken when branch enable is set and the selected final-row column is non-zero. `next_pc` becomes the immediate when the branch is taken, and otherwise the program counter plus four times the instruction count.
- R12: Writes to one context leave every other context's configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 2 | Context written |
| cfg_slot | input | 6 | Slot within the context (0-31 units, 32 header) |
| cfg_data | input | 19 | Configuration word |
| ex_start | input | 1 | Begin a custom instruction |
| ex_ctx | input | 2 | Context to execute |
| ex_opnd | input | 448 | Fourteen 32-bit operand slots, slot i at [32i+31:32i] |
| ex_imm | input | 32 | Immediate and branch target |
| ex_pc | input | 32 | Program counter of the instruction |
| ex_done | output | 1 | Completion pulse |
| ex_busy | output | 1 | Instruction in flight |
| ex_result | output | 128 | Final-row unit outputs |
| st_valid | output | 1 | Store request pulse |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| br_taken | output | 1 | Branch outcome of the last instruction |
| next_pc | output | 32 | Program counter to continue from |

## Verification
A wrong select or opcode decode inside the grid shows up at `ex_done` of the very next instruction that uses that unit, as a bad result column, store field or branch decision. A wrong entry in the depth-to-latency count shows up as `ex_done` arriving on the wrong edge, or as results taken from the wrong row. Each of these is visible within four cycles of the start. A fault in the busy/accept logic shows up as an extra or missing completion pulse when starts are issued back to back.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
   localparam int NROWS = 8;
   localparam int MAXIN = 7;
   localparam int OPW   = 4;
   localparam int SELW  = 5;
   localparam int SHW   = 5;
   localparam int CW    = OPW + 2*SELW + SHW;

   typedef enum logic [OPW-1:0] {
      OP_PASS = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_AND  = 4'd3,
      OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_NOR  = 4'd6,  OP_SLL  = 4'd7,
      OP_SRL  = 4'd8,  OP_SRA  = 4'd9,  OP_SLT  = 4'd10, OP_SLTU = 4'd11,
      OP_SEQ  = 4'd12, OP_SNE  = 4'd13
   } fu_op_e;

   localparam int SRC_EXT0  = 8;
   localparam int SRC_IMM   = 16;
   localparam int SRC_LINK0 = 17;
   localparam int SRC_LINK1 = 18;
   localparam int SRC_LEFT  = 19;

   function automatic int row_nin(input int r);
      case (r)
         0:       return 7;
         1, 2, 3: return 2;
         4:       return 1;
         default: return 0;
      endcase
   endfunction

   function automatic int row_base(input int r);
      int s;
      s = 0;
      for (int i = 0; i < r; i++) s += row_nin(i);
      return s;
   endfunction

   // origin row of long link k into row r, -1 when absent
   function automatic int link_origin(input int r, input int k);
      if (k == 0 && (r == 2 || r == 3 || r == 4)) return 0;
      if (k == 1 && r == 3) return 1;
      return -1;
   endfunction

   function automatic bit row_has_left(input int r);
      return (r == 2 || r == 3);
   endfunction

   localparam int NEXT = row_base(NROWS);
endpackage

// File: rtl/rfu_fu.sv
module rfu_fu
   import rfu_pkg::*;
#(
   parameter int DW = 32
) (
   input  fu_op_e          op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic [SHW-1:0]  sh,
   output logic [DW-1:0]   y
);
   always_comb begin
      y = '0;
      case (op)
         OP_PASS: y = a;
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOR:  y = ~(a | b);
         OP_SLL:  y = a << sh;
         OP_SRL:  y = a >> sh;
         OP_SRA:  y = $unsigned($signed(a) >>> sh);
         OP_SLT:  y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
         OP_SLTU: y = {{(DW-1){1'b0}}, (a < b)};
         OP_SEQ:  y = {{(DW-1){1'b0}}, (a == b)};
         OP_SNE:  y = {{(DW-1){1'b0}}, (a != b)};
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/rfu_row.sv
module rfu_row
   import rfu_pkg::*;
#(
   parameter int DW  = 32,
   parameter int FPR = 4,
   parameter int ROW = 0
) (
   input  logic [FPR*CW-1:0]   cfg,
   input  logic [FPR*DW-1:0]   prev,
   input  logic [MAXIN*DW-1:0] ext,
   input  logic [DW-1:0]       link0,
   input  logic [DW-1:0]       link1,
   input  logic [DW-1:0]       imm,
   output logic [FPR*DW-1:0]   q
);
   localparam int NIN = row_nin(ROW);
   localparam bit HZ  = row_has_left(ROW);

   logic [DW-1:0] col_y [FPR];
   logic          unused_row;
   assign unused_row = ^{prev, ext, link0, link1};

   function automatic logic [DW-1:0] pick(input logic [SELW-1:0] s,
                                          input logic [DW-1:0]   left);
      logic [DW-1:0] v;
      v = '0;
      for (int j = 0; j < FPR; j++)
         if (ROW > 0 && int'(s) == j) v = prev[j*DW +: DW];
      for (int k = 0; k < NIN; k++)
         if (int'(s) == SRC_EXT0 + k) v = ext[k*DW +: DW];
      if (int'(s) == SRC_IMM)   v = imm;
      if (int'(s) == SRC_LINK0) v = link0;
      if (int'(s) == SRC_LINK1) v = link1;
      if (int'(s) == SRC_LEFT)  v = left;
      return v;
   endfunction

   for (genvar c = 0; c < FPR; c++) begin : g_col
      logic [CW-1:0] w;
      logic [DW-1:0] left_v, a_v, b_v;
      assign w = cfg[c*CW +: CW];
      if (HZ && c > 0) begin : g_left
         assign left_v = col_y[c-1];
      end else begin : g_noleft
         assign left_v = '0;
      end
      assign a_v = pick(w[OPW +: SELW], left_v);
      assign b_v = pick(w[OPW+SELW +: SELW], left_v);
      rfu_fu #(.DW(DW)) u_fu (
         .op (fu_op_e'(w[OPW-1:0])),
         .a  (a_v),
         .b  (b_v),
         .sh (w[OPW+2*SELW +: SHW]),
         .y  (col_y[c])
      );
      assign q[c*DW +: DW] = col_y[c];
   end
endmodule

// File: rtl/rfu_cfg_mem.sv
module rfu_cfg_mem
   import rfu_pkg::*;
#(
   parameter int NCTX  = 4,
   parameter int NSLOT = 33,
   localparam int CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1,
   localparam int SLOTW = $clog2(NSLOT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [CTXW-1:0]       wctx,
   input  logic [SLOTW-1:0]      wslot,
   input  logic [CW-1:0]         wdata,
   input  logic [CTXW-1:0]       rctx,
   output logic [NSLOT*CW-1:0]   rdata
);
   logic [NSLOT*CW-1:0] mem [NCTX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCTX; i++) mem[i] <= '0;
      end else if (we && int'(wctx) < NCTX && int'(wslot) < NSLOT) begin
         mem[wctx][int'(wslot)*CW +: CW] <= wdata;
      end
   end

   assign rdata = mem[rctx];
endmodule

// File: rtl/rfu_array.sv
module rfu_array
   import rfu_pkg::*;
#(
   parameter int DW   = 32,
   parameter int FPR  = 4,
   parameter int NCTX = 4,
   localparam int NFU   = NROWS * FPR,
   localparam int NSLOT = NFU + 1,
   localparam int SLOTW = $clog2(NSLOT),
   localparam int CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CTXW-1:0]     cfg_ctx,
   input  logic [SLOTW-1:0]    cfg_slot,
   input  logic [CW-1:0]       cfg_data,
   input  logic                ex_start,
   input  logic [CTXW-1:0]     ex_ctx,
   input  logic [NEXT*DW-1:0]  ex_opnd,
   input  logic [DW-1:0]       ex_imm,
   input  logic [DW-1:0]       ex_pc,
   output logic                ex_done,
   output logic                ex_busy,
   output logic [FPR*DW-1:0]   ex_result,
   output logic                st_valid,
   output logic [DW-1:0]       st_addr,
   output logic [DW-1:0]       st_data,
   output logic                br_taken,
   output logic [DW-1:0]       next_pc
);
   localparam int CB   = (FPR > 1) ? $clog2(FPR) : 1;
   localparam int CNTW = 3;

   if (FPR < 1 || FPR > 8) begin : g_bad_fpr
      $error("FPR must lie in 1..8");
   end
   if (DW < 32) begin : g_bad_dw
      $error("DW must be at least 32");
   end
   if (10 + 3*CB > CW) begin : g_bad_hdr
      $error("header fields exceed the configuration word");
   end

   // latched instruction
   logic [CTXW-1:0]    lat_ctx;
   logic [NEXT*DW-1:0] lat_opnd;
   logic [DW-1:0]      lat_imm, lat_pc;
   logic [CNTW-1:0]    cnt;

   logic [NSLOT*CW-1:0] ctx_words;
   rfu_cfg_mem #(.NCTX(NCTX), .NSLOT(NSLOT)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wctx  (cfg_ctx),
      .wslot (cfg_slot),
      .wdata (cfg_data),
      .rctx  (lat_ctx),
      .rdata (ctx_words)
   );

   // header decode
   logic [CW-1:0] hdr;
   logic [3:0]    hd_depth, hd_ninsn;
   logic          hd_br, hd_st;
   logic [CB-1:0] hd_brc, hd_sac, hd_sdc;
   logic          unused_hdr;
   assign hdr      = ctx_words[NFU*CW +: CW];
   assign hd_depth = hdr[3:0];
   assign hd_br    = hdr[4];
   assign hd_st    = hdr[5];
   assign hd_ninsn = hdr[9:6];
   assign hd_brc   = hdr[10 +: CB];
   assign hd_sac   = hdr[10+CB +: CB];
   assign hd_sdc   = hdr[10+2*CB +: CB];
   assign unused_hdr = ^hdr;

   int eff_depth;
   always_comb begin
      if (hd_depth == 4'd0)              eff_depth = 1;
      else if (int'(hd_depth) > NROWS)   eff_depth = NROWS;
      else                               eff_depth = int'(hd_depth);
   end

   logic [CNTW-1:0] lat_cyc;
   assign lat_cyc = CNTW'((eff_depth + 1) / 2);

   // the grid
   logic [FPR*DW-1:0] row_q [NROWS];
   for (genvar r = 0; r < NROWS; r++) begin : g_row
      logic [FPR*DW-1:0]   prev_v;
      logic [MAXIN*DW-1:0] ext_v;
      logic [DW-1:0]       l0, l1;
      if (r == 0) begin : g_top
         assign prev_v = '0;
      end else begin : g_inner
         assign prev_v = row_q[r-1];
      end
      for (genvar i = 0; i < MAXIN; i++) begin : g_in
         if (i < row_nin(r)) begin : g_on
            assign ext_v[i*DW +: DW] = lat_opnd[(row_base(r)+i)*DW +: DW];
         end else begin : g_off
            assign ext_v[i*DW +: DW] = '0;
         end
      end
      if (link_origin(r, 0) >= 0) begin : g_l0
         assign l0 = row_q[link_origin(r, 0)][(FPR-1)*DW +: DW];
      end else begin : g_nol0
         assign l0 = '0;
      end
      if (link_origin(r, 1) >= 0) begin : g_l1
         assign l1 = row_q[link_origin(r, 1)][(FPR-1)*DW +: DW];
      end else begin : g_nol1
         assign l1 = '0;
      end
      rfu_row #(.DW(DW), .FPR(FPR), .ROW(r)) u_row (
         .cfg   (ctx_words[r*FPR*CW +: FPR*CW]),
         .prev  (prev_v),
         .ext   (ext_v),
         .link0 (l0),
         .link1 (l1),
         .imm   (lat_imm),
         .q     (row_q[r])
      );
   end

   // final row and its selected columns
   logic [FPR*DW-1:0] fin_q;
   logic [DW-1:0]     br_v, sa_v, sd_v;
   always_comb begin
      fin_q = row_q[0];
      for (int r = 1; r < NROWS; r++)
         if (r == eff_depth - 1) fin_q = row_q[r];
      br_v = '0; sa_v = '0; sd_v = '0;
      for (int c = 0; c < FPR; c++) begin
         if (int'(hd_brc) == c) br_v = fin_q[c*DW +: DW];
         if (int'(hd_sac) == c) sa_v = fin_q[c*DW +: DW];
         if (int'(hd_sdc) == c) sd_v = fin_q[c*DW +: DW];
      end
   end

   logic taken_c;
   assign taken_c = hd_br && (br_v != '0);

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_busy   <= 1'b0;
         ex_done   <= 1'b0;
         cnt       <= '0;
         lat_ctx   <= '0;
         lat_opnd  <= '0;
         lat_imm   <= '0;
         lat_pc    <= '0;
         ex_result <= '0;
         st_valid  <= 1'b0;
         st_addr   <= '0;
         st_data   <= '0;
         br_taken  <= 1'b0;
         next_pc   <= '0;
      end else begin
         ex_done  <= 1'b0;
         st_valid <= 1'b0;
         if (!ex_busy) begin
            if (ex_start) begin
               ex_busy  <= 1'b1;
               cnt      <= '0;
               lat_ctx  <= ex_ctx;
               lat_opnd <= ex_opnd;
               lat_imm  <= ex_imm;
               lat_pc   <= ex_pc;
            end
         end else if (cnt + 1'b1 == lat_cyc) begin
            ex_busy   <= 1'b0;
            ex_done   <= 1'b1;
            ex_result <= fin_q;
            st_valid  <= hd_st;
            st_addr   <= sa_v;
            st_data   <= sd_v;
            br_taken  <= taken_c;
            next_pc   <= taken_c ? lat_imm : lat_pc + DW'({hd_ninsn, 2'b00});
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ex_done |=> !ex_done);
   // R7: the block is idle while it reports completion
   a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      ex_done |-> !ex_busy);
   // R8: a start during an instruction does not replace the latched context
   a_r8_keep_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      ex_busy && ex_start |=> lat_ctx == $past(lat_ctx));
   // R9: results only move on a completion
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_done |-> $stable(ex_result));
   // R10: store requests ride on completion
   a_r10_store_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> ex_done);
   // R11: a taken branch redirects to the immediate
   a_r11_target: assert property (@(posedge clk) disable iff (!rst_n)
      ex_done && br_taken |-> next_pc == lat_imm);
endmodule

// File: tb/rfu_array_bench.sv
module rfu_array_bench;
   import rfu_pkg::*;

   localparam int DW = 32;
   localparam int FPR = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_we = 1'b0;
   logic [1:0]          cfg_ctx = '0;
   logic [5:0]          cfg_slot = '0;
   logic [CW-1:0]       cfg_data = '0;
   logic                ex_start = 1'b0;
   logic [1:0]          ex_ctx = '0;
   logic [NEXT*DW-1:0]  ex_opnd = '0;
   logic [DW-1:0]       ex_imm = '0, ex_pc = '0;
   logic                ex_done, ex_busy, st_valid, br_taken;
   logic [FPR*DW-1:0]   ex_result;
   logic [DW-1:0]       st_addr, st_data, next_pc;

   rfu_array u_rfu_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
      .cfg_slot(cfg_slot), .cfg_data(cfg_data), .ex_start(ex_start),
      .ex_ctx(ex_ctx), .ex_opnd(ex_opnd), .ex_imm(ex_imm), .ex_pc(ex_pc),
      .ex_done(ex_done), .ex_busy(ex_busy), .ex_result(ex_result),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .br_taken(br_taken), .next_pc(next_pc)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] fw(input int op, input int a, input int b, input int sh);
      return {sh[4:0], b[4:0], a[4:0], op[3:0]};
   endfunction

   function automatic logic [CW-1:0] hw(input int d, input int br, input int st, input int n,
                                        input int bc, input int sac, input int sdc);
      return {3'b000, sdc[1:0], sac[1:0], bc[1:0], n[3:0], st[0], br[0], d[3:0]};
   endfunction

   task automatic wr(input int ctx, input int slot, input logic [CW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ctx = ctx[1:0]; cfg_slot = slot[5:0]; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setin(input int idx, input logic [DW-1:0] v);
      ex_opnd[idx*DW +: DW] = v;
   endtask

   task automatic run(input int ctx, output int lat);
      @(negedge clk);
      ex_start = 1'b1; ex_ctx = ctx[1:0];
      @(negedge clk);
      ex_start = 1'b0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!ex_done && lat < 20);
   endtask

   function automatic logic [DW-1:0] col(input int c);
      return ex_result[c*DW +: DW];
   endfunction

   // stimulus for context 0: x, y, z, in3, in7, pc, imm
   localparam int NVA = 5;
   localparam logic [7*32-1:0] VEC_A [NVA] = '{
      {32'd5,        32'd16,        32'd0, 32'd100,        32'd3,        32'h1000, 32'h2000},
      {32'hFFFFFFF6, 32'd8,         32'd8, 32'd7,          32'hF0000001, 32'h400,  32'h800},
      {32'd1,        32'h80000000,  32'd0, 32'hFFFFFFFF,   32'h08000000, 32'h40,   32'h80},
      {32'd0,        32'd0,         32'd0, 32'd0,          32'd0,        32'd0,    32'h10},
      {32'h80000000, 32'h7FFFFFF8,  32'd0, 32'h10,         32'd1,        32'h100,  32'h300}
   };

   task automatic apply_a(input int i);
      logic [7*32-1:0] v;
      v = VEC_A[i];
      ex_opnd = '0;
      setin(0, v[6*32 +: 32]); setin(1, v[5*32 +: 32]); setin(2, v[4*32 +: 32]);
      setin(3, v[3*32 +: 32]); setin(7, v[2*32 +: 32]);
      ex_pc = v[32 +: 32]; ex_imm = v[0 +: 32];
   endtask

   task automatic expect_a(input int i, input string tag);
      logic [7*32-1:0] v;
      logic [31:0] x, y, z, i3, i7, pc, imm, nx, sum, sr, s, npc;
      v = VEC_A[i];
      x = v[6*32 +: 32]; y = v[5*32 +: 32]; z = v[4*32 +: 32];
      i3 = v[3*32 +: 32]; i7 = v[2*32 +: 32]; pc = v[32 +: 32]; imm = v[0 +: 32];
      nx  = 32'd0 - x;
      sum = y + z;
      sr  = $unsigned($signed(sum) >>> 3);
      s   = ($signed(nx) < $signed(sr)) ? 32'd1 : 32'd0;
      npc = (s != 0) ? imm : pc + 32'd20;
      check({tag, " R2 slt col0"}, col(0), s);
      check({tag, " R4 R5 link+left col1"}, col(1), i3 + s);
      check({tag, " R3 R2 sll col2"}, col(2), i7 << 4);
      check({tag, " R6 default col3"}, col(3), s);
      check({tag, " R11 next_pc"}, next_pc, npc);
      check({tag, " R11 br_taken"}, {31'd0, br_taken}, s);
      check({tag, " R10 st_valid"}, {31'd0, st_valid}, 32'd1);
      check({tag, " R10 st_addr"}, st_addr, i3 + s);
      check({tag, " R10 st_data"}, st_data, s);
   endtask

   task automatic b_case(input logic [31:0] i0, i6, i7, i8, i13, imm, pc);
      logic [31:0] v1, v2, v3, v4, v5, v6, v7;
      int lat;
      ex_opnd = '0;
      setin(0, i0); setin(6, i6); setin(7, i7); setin(8, i8); setin(13, i13);
      ex_imm = imm; ex_pc = pc;
      run(1, lat);
      v1 = i0 ^ i7; v2 = v1 & i6; v3 = v2 | i8; v4 = v3 - i13;
      v5 = v4 >> 1; v6 = (v5 < imm) ? 32'd1 : 32'd0; v7 = ~v6;
      check("R7 depth-8 latency", lat, 4);
      check("R2 R3 R4 deep chain col0", col(0), v7);
      check("R6 default pass col1", col(1), v6);
      check("R11 fall-through next_pc", next_pc, pc + 32'd32);
      check("R10 no store", {31'd0, st_valid}, 32'd0);
   endtask

   task automatic c_case(input logic [31:0] i0, i1, imm, pc);
      logic [31:0] ne;
      int lat;
      ex_opnd = '0;
      setin(0, i0); setin(1, i1);
      ex_imm = imm; ex_pc = pc;
      run(2, lat);
      ne = (i0 != i1) ? 32'd1 : 32'd0;
      check("R7 depth-1 latency", lat, 1);
      check("R3 row0 pass col0", col(0), i0);
      check("R5 no left link in row0 col1", col(1), i1);
      check("R2 sne col2", col(2), ne);
      check("R2 seq col3", col(3), ne ^ 32'd1);
      check("R11 sne branch next_pc", next_pc, (ne != 0) ? imm : pc + 32'd4);
      check("R10 st_addr", st_addr, i0);
      check("R10 st_data", st_data, i1);
      check("R10 st_valid", {31'd0, st_valid}, 32'd1);
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #4000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      int lat, dcount;
      repeat (3) @(negedge clk);
      // R1: state under reset
      check("R1 done in reset", {31'd0, ex_done}, 32'd0);
      check("R1 busy in reset", {31'd0, ex_busy}, 32'd0);
      check("R1 next_pc in reset", next_pc, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 result after reset", col(0) | col(1) | col(2) | col(3), 32'd0);
      check("R1 store/branch after reset", {30'd0, st_valid, br_taken}, 32'd0);

      // context 0: sub / add / sra / sll / slt / link / left / branch / store
      wr(0, 0,  fw(2, 20, 8, 0));
      wr(0, 1,  fw(1, 9, 10, 0));
      wr(0, 3,  fw(0, 11, 0, 0));
      wr(0, 4,  fw(0, 0, 0, 0));
      wr(0, 5,  fw(9, 1, 0, 3));
      wr(0, 6,  fw(7, 8, 0, 4));
      wr(0, 8,  fw(10, 0, 1, 0));
      wr(0, 10, fw(0, 2, 0, 0));
      wr(0, 12, fw(0, 0, 0, 0));
      wr(0, 13, fw(1, 19, 17, 0));
      wr(0, 14, fw(0, 2, 0, 0));
      wr(0, 32, hw(4, 1, 1, 5, 0, 1, 0));

      for (int i = 0; i < NVA; i++) begin
         apply_a(i);
         run(0, lat);
         check("R7 depth-4 latency", lat, 2);
         expect_a(i, "vecA");
         repeat (3) @(negedge clk);
         check("R9 result held", col(1), VEC_A[i][3*32 +: 32] + col(0));
      end

      // context 1: depth 8 with deep rows and both links into row 3
      wr(1, 0,  fw(0, 8, 0, 0));
      wr(1, 3,  fw(0, 14, 0, 0));
      wr(1, 4,  fw(5, 0, 8, 0));
      wr(1, 7,  fw(0, 9, 0, 0));
      wr(1, 8,  fw(3, 0, 17, 0));
      wr(1, 12, fw(4, 0, 18, 0));
      wr(1, 16, fw(2, 0, 8, 0));
      wr(1, 20, fw(8, 0, 0, 1));
      wr(1, 24, fw(11, 0, 16, 0));
      wr(1, 28, fw(6, 0, 20, 0));
      wr(1, 32, hw(8, 0, 0, 8, 0, 0, 0));
      b_case(32'hF0F0F0F0, 32'hFFFF0000, 32'h0FF00FF0, 32'h0000000F, 32'h10, 32'h80000000, 32'h2000);
      b_case(32'h12345678, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'd5, 32'h3000);

      // context 2: depth 1, compare-driven branch, store
      wr(2, 0,  fw(0, 8, 0, 0));
      wr(2, 1,  fw(1, 19, 9, 0));
      wr(2, 2,  fw(13, 8, 9, 0));
      wr(2, 3,  fw(12, 8, 9, 0));
      wr(2, 32, hw(1, 1, 1, 1, 2, 0, 1));
      c_case(32'd7, 32'd9, 32'h5000, 32'h100);
      c_case(32'hAB, 32'hAB, 32'h5000, 32'h200);

      // R12: context 0 unchanged by later writes to other contexts
      apply_a(0);
      run(0, lat);
      expect_a(0, "R12 ctx0 after others");

      // R8: a second start while busy is ignored
      apply_a(4);
      @(negedge clk);
      ex_start = 1'b1; ex_ctx = 2'd0;
      @(negedge clk);
      ex_ctx = 2'd1; ex_opnd = '0; ex_imm = 32'hDEAD0000;
      @(negedge clk);
      ex_start = 1'b0;
      check("R8 no early done", {31'd0, ex_done}, 32'd0);
      @(negedge clk);
      check("R8 done on time", {31'd0, ex_done}, 32'd1);
      apply_a(4);
      expect_a(4, "R8 first instr kept");
      dcount = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (ex_done) dcount++;
      end
      check("R8 no extra done", dcount, 0);

      finish_up();
   end
endmodule